// File: doc/BRIEF.md
# Integrator Leakage and Offset Estimator

This built-in self-test block measures two imperfections of a first- or second-order low-pass sigma-delta modulator: the leakage of its first integrator and its input-referred offset. It plays a programmable bit pattern into the modulator as a stimulus with a known nonzero mean. It then replays the same pattern inverted. In each of the two passes it accumulates the modulator's one-bit output as a signed ±1 count over N samples.

Leakage moves the two counts in opposite directions, while offset moves them together. The block therefore reports the difference of the two counts as the leakage numerator and the negated sum as the offset numerator. Software, or a later stage, divides these by 4·N·Q and 2·N, where Q is the stimulus mean. When those divisors are powers of two, the arithmetic right-shifted copies of the numerators give the quotients directly.

Each pass begins with a programmable number of discarded settling samples. The window length N is checked to be a whole multiple of the pattern period before a run is accepted.

Top module: `leak_offset_bist`

## Requirements
- R1: While a pass runs, `stim_bit` equals `pattern[i]`, where i starts at 0 on the first cycle of each pass and steps by one per cycle, wrapping after `period`-1. The positive pass emits the pattern as stored and the negative pass emits it inverted. When no pass runs, `stim_bit` is 0.
- R2: Each counted sample adds +1 to the pass count when `mod_bit` is 1 and −1 when it is 0. Each pass counts exactly `n_samples` samples.
- R3: The first `settle_len` samples of each pass are discarded, and counting starts on the sample after them.
- R4: On completion, `leak_num` equals the positive-pass count minus the negative-pass count.
- R5: On completion, `offs_num` equals the negated sum of the two pass counts.
- R6: `leak_shr` equals `leak_num` arithmetically shifted right by `lk_shift`, and `offs_shr` equals `offs_num` arithmetically shifted right by `of_shift`.
- R7: `busy` is high from the cycle after an accepted start for exactly 2·(`settle_len`+`n_samples`) cycles. `done` then rises and, together with both results, holds until the next start. `busy` and `done` are never high together.
- R8: A start request while `busy` is high is ignored. It changes neither the timing nor the results.
- R9: A start is rejected with `cfg_err` if any of these holds: `period` is 0, `period` exceeds the pattern width, `n_samples` is 0, or `n_samples` is not a multiple of `period`. On rejection, `done` and `cfg_err` rise the next cycle, both results read 0, and no stimulus is emitted. A valid start clears `cfg_err`.
- R10: After reset, the block is idle: `busy`, `done`, `cfg_err`, `stim_bit` and both results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Measurement start request |
| pattern | input | PAT_MAX | Stimulus pattern; bit i plays at step i |
| period | input | PW | Pattern period P in steps |
| n_samples | input | NW | Counted samples N per pass |
| settle_len | input | SW | Discarded samples at the start of each pass |
| lk_shift | input | SHW | Right shift applied to the leakage numerator |
| of_shift | input | SHW | Right shift applied to the offset numerator |
| mod_bit | input | 1 | One-bit modulator output |
| stim_bit | output | 1 | Stimulus bit to the modulator |
| busy | output | 1 | A measurement pass is running |
| done | output | 1 | Results are valid |
| cfg_err | output | 1 | Last start was rejected for bad configuration |
| leak_num | output | RW | Signed leakage numerator |
| offs_num | output | RW | Signed offset numerator |
| leak_shr | output | RW | Shifted leakage numerator |
| offs_shr | output | RW | Shifted offset numerator |

## Verification
A wrong pattern index or inversion flag shows on `stim_bit` in the very cycle it occurs. The bench compares that pin against the expected bit on every cycle of a run. An error in a settle or sample counter shifts the cycle in which `done` rises, and the bench catches it at the exact expected edge. Corruption of the accumulator or of the stored positive count becomes visible only when `done` rises. It appears as a wrong value on `leak_num` and `offs_num`, which the bench checks against counts derived from stimuli whose sums are known in closed form, including a settle-window drive that separates discarded samples from counted ones.

// File: rtl/lob_pkg.sv
package lob_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POS  = 2'd1,
        ST_NEG  = 2'd2,
        ST_DONE = 2'd3
    } lob_state_e;
endpackage

// File: rtl/lob_stim.sv
module lob_stim #(
    parameter int PAT_MAX = 16,
    parameter int PW      = $clog2(PAT_MAX + 1),
    parameter int IW      = $clog2(PAT_MAX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               restart,
    input  logic               advance,
    input  logic               invert,
    input  logic [PAT_MAX-1:0] pattern,
    input  logic [PW-1:0]      period,
    output logic               stim_bit
);
    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (restart) begin
            idx_d = '0;
        end else if (advance) begin
            if (int'(idx_q) >= int'(period) - 1) idx_d = '0;
            else                                 idx_d = idx_q + IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign stim_bit = en & (pattern[idx_q] ^ invert);
endmodule

// File: rtl/lob_accum.sv
module lob_accum #(
    parameter int CW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 bit_in,
    output logic signed [CW-1:0] count
);
    logic signed [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)     cnt_d = '0;
        else if (en) cnt_d = bit_in ? cnt_q + CW'(1) : cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/leak_offset_bist.sv
module leak_offset_bist
    import lob_pkg::*;
#(
    parameter int PAT_MAX = 16,
    parameter int NW      = 16,
    parameter int SW      = 8,
    localparam int PW     = $clog2(PAT_MAX + 1),
    localparam int RW     = NW + 3,
    localparam int SHW    = $clog2(RW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PAT_MAX-1:0]   pattern,
    input  logic [PW-1:0]        period,
    input  logic [NW-1:0]        n_samples,
    input  logic [SW-1:0]        settle_len,
    input  logic [SHW-1:0]       lk_shift,
    input  logic [SHW-1:0]       of_shift,
    input  logic                 mod_bit,
    output logic                 stim_bit,
    output logic                 busy,
    output logic                 done,
    output logic                 cfg_err,
    output logic signed [RW-1:0] leak_num,
    output logic signed [RW-1:0] offs_num,
    output logic signed [RW-1:0] leak_shr,
    output logic signed [RW-1:0] offs_shr
);
    localparam int CW   = NW + 2;
    localparam int CNTW = (SW > NW) ? SW : NW;
    localparam int IW   = $clog2(PAT_MAX);

    typedef struct packed {
        lob_state_e           st;
        logic                 counting;
        logic [CNTW-1:0]      cnt;
        logic signed [CW-1:0] pos;
        logic signed [RW-1:0] leak;
        logic signed [RW-1:0] offs;
        logic                 err;
    } regs_t;

    regs_t r_d, r_q;

    logic                 stim_restart, stim_adv, acc_clr, acc_en;
    logic signed [CW-1:0] acc_cnt, samp, end_val;
    logic                 period_ok, cfg_bad, run;
    logic [NW-1:0]        n_rem;

    assign run = (r_q.st == ST_POS) || (r_q.st == ST_NEG);

    lob_stim #(.PAT_MAX(PAT_MAX), .PW(PW), .IW(IW)) u_stim (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run),
        .restart  (stim_restart),
        .advance  (stim_adv),
        .invert   (r_q.st == ST_NEG),
        .pattern  (pattern),
        .period   (period),
        .stim_bit (stim_bit)
    );

    lob_accum #(.CW(CW)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acc_clr),
        .en     (acc_en),
        .bit_in (mod_bit),
        .count  (acc_cnt)
    );

    // configuration check
    always_comb begin
        period_ok = (period != '0) && (int'(period) <= PAT_MAX);
        n_rem     = period_ok ? (n_samples % NW'(period)) : '0;
        cfg_bad   = !period_ok || (n_samples == '0) || (n_rem != '0);
    end

    assign samp    = mod_bit ? CW'(1) : '1;
    assign end_val = acc_cnt + samp;

    always_comb begin
        r_d          = r_q;
        stim_restart = 1'b0;
        stim_adv     = 1'b0;
        acc_clr      = 1'b0;
        acc_en       = 1'b0;
        unique case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    if (cfg_bad) begin
                        r_d.st   = ST_DONE;
                        r_d.err  = 1'b1;
                        r_d.leak = '0;
                        r_d.offs = '0;
                    end else begin
                        r_d.st       = ST_POS;
                        r_d.err      = 1'b0;
                        r_d.cnt      = '0;
                        r_d.counting = (settle_len == '0);
                        stim_restart = 1'b1;
                        acc_clr      = 1'b1;
                    end
                end
            end
            ST_POS, ST_NEG: begin
                stim_adv = 1'b1;
                if (!r_q.counting) begin
                    if (r_q.cnt == CNTW'(settle_len) - CNTW'(1)) begin
                        r_d.counting = 1'b1;
                        r_d.cnt      = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + CNTW'(1);
                    end
                end else begin
                    acc_en = 1'b1;
                    if (r_q.cnt == CNTW'(n_samples) - CNTW'(1)) begin
                        if (r_q.st == ST_POS) begin
                            r_d.pos      = end_val;
                            r_d.st       = ST_NEG;
                            r_d.cnt      = '0;
                            r_d.counting = (settle_len == '0);
                            stim_restart = 1'b1;
                            acc_clr      = 1'b1;
                        end else begin
                            r_d.leak = RW'(r_q.pos) - RW'(end_val);
                            r_d.offs = -(RW'(r_q.pos) + RW'(end_val));
                            r_d.st   = ST_DONE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + CNTW'(1);
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = run;
    assign done     = (r_q.st == ST_DONE);
    assign cfg_err  = r_q.err;
    assign leak_num = r_q.leak;
    assign offs_num = r_q.offs;
    assign leak_shr = r_q.leak >>> lk_shift;
    assign offs_shr = r_q.offs >>> of_shift;
endmodule

// File: rtl/lob_checker.sv
module lob_checker #(
    parameter int RW = 19
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 cfg_err,
    input logic                 stim_bit,
    input logic signed [RW-1:0] leak_num,
    input logic signed [RW-1:0] offs_num
);
    a_r1_stim_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !stim_bit);

    a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r7_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(leak_num) && $stable(offs_num)));

    a_r8_err_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_err));

    a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (leak_num == '0 && offs_num == '0));

    // R4 and R5 together: leak + offs = -2*neg count, always even
    a_r5_parity: assert property (@(posedge clk) disable iff (!rst_n)
        leak_num[0] == offs_num[0]);
endmodule

bind leak_offset_bist lob_checker #(.RW(RW)) u_lob_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .cfg_err  (cfg_err),
    .stim_bit (stim_bit),
    .leak_num (leak_num),
    .offs_num (offs_num)
);

// File: tb/leak_offset_bist_bench.sv
`timescale 1ns/1ps
module leak_offset_bist_bench;
    localparam int PAT_MAX = 16;
    localparam int NW      = 16;
    localparam int SW      = 8;
    localparam int PW      = $clog2(PAT_MAX + 1);
    localparam int RW      = NW + 3;
    localparam int SHW     = $clog2(RW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [PAT_MAX-1:0] pattern = '0;
    logic [PW-1:0] period = '0;
    logic [NW-1:0] n_samples = '0;
    logic [SW-1:0] settle_len = '0;
    logic [SHW-1:0] lk_shift = '0, of_shift = '0;
    logic mod_bit, stim_bit, busy, done, cfg_err;
    logic signed [RW-1:0] leak_num, offs_num, leak_shr, offs_shr;

    int  mode = 1;       // 0 echo, 1 manual, 2 modulator model
    logic man_bit = 1'b0;
    int  integ;
    int  n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    // ideal first-order modulator model (bench only)
    always_ff @(posedge clk) begin
        if (!rst_n) integ <= 0;
        else        integ <= integ + (stim_bit ? 1 : -1) - ((integ >= 0) ? 1 : -1);
    end

    assign mod_bit = (mode == 0) ? stim_bit : (mode == 2) ? (integ >= 0) : man_bit;

    leak_offset_bist #(.PAT_MAX(PAT_MAX), .NW(NW), .SW(SW)) u_leak_offset_bist (
        .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern), .period(period),
        .n_samples(n_samples), .settle_len(settle_len), .lk_shift(lk_shift),
        .of_shift(of_shift), .mod_bit(mod_bit), .stim_bit(stim_bit), .busy(busy),
        .done(done), .cfg_err(cfg_err), .leak_num(leak_num), .offs_num(offs_num),
        .leak_shr(leak_shr), .offs_shr(offs_shr)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // run one measurement; manual modes: 1 constant man_bit, 3 high only in settle
    task automatic run(input int s, input int n, input int p, input logic [PAT_MAX-1:0] pat,
                       input int md, input bit glitch);
        int L;
        L = s + n;
        pattern = pat; period = PW'(p); n_samples = NW'(n); settle_len = SW'(s);
        mode = (md == 3) ? 1 : md;
        @(negedge clk); start = 1'b1;
        @(posedge clk); @(negedge clk); start = 1'b0;
        for (int c = 0; c < 2 * L; c++) begin
            logic exp_stim;
            exp_stim = pat[(c % L) % p] ^ (c >= L);
            check(stim_bit == exp_stim, "R1 stim bit", stim_bit, exp_stim);
            if (md == 3) man_bit = ((c % L) < s);
            if (glitch) start = (c == 5);
            if (c == 2 * L - 1) begin
                check(busy == 1'b1, "R7 busy in last cycle", busy, 1);
                check(done == 1'b0, "R7 done not early", done, 0);
            end
            @(posedge clk); @(negedge clk);
        end
        start = 1'b0;
        check(done == 1'b1, "R7 done after 2(S+N) cycles", done, 1);
        check(busy == 1'b0, "R7 busy low when done", busy, 0);
        check(stim_bit == 1'b0, "R1 stim quiet when done", stim_bit, 0);
    endtask

    task automatic t_reset();
        check(busy == 0, "R10 busy", busy, 0);
        check(done == 0, "R10 done", done, 0);
        check(cfg_err == 0, "R10 cfg_err", cfg_err, 0);
        check(stim_bit == 0, "R10 stim", stim_bit, 0);
        check(leak_num == 0, "R10 leak", leak_num, 0);
        check(offs_num == 0, "R10 offs", offs_num, 0);
    endtask

    // echo: P=5, 3 ones, N=20 -> pos +4, neg -4
    task automatic t_echo();
        run(2, 20, 5, 16'b00111, 0, 0);
        check(leak_num == 8, "R4 echo leak", leak_num, 8);
        check(offs_num == 0, "R5 echo offs", offs_num, 0);
        check(cfg_err == 0, "R9 err clear on valid start", cfg_err, 0);
    endtask

    // constant 1: pos +16, neg +16
    task automatic t_const();
        man_bit = 1'b1;
        run(2, 16, 4, 16'b0101, 1, 0);
        check(leak_num == 0, "R4 const leak", leak_num, 0);
        check(offs_num == -32, "R2 R5 const offs", offs_num, -32);
        of_shift = 5; lk_shift = 0;
        #1;
        check(offs_shr == -1, "R6 offs shift 5", offs_shr, -1);
        of_shift = 3;
        #1;
        check(offs_shr == -4, "R6 offs shift 3", offs_shr, -4);
        check(leak_shr == 0, "R6 leak shift", leak_shr, 0);
    endtask

    // high only in settle windows: discarded -> both counts -8; start glitch ignored
    task automatic t_settle();
        run(3, 8, 4, 16'b0011, 3, 1);
        check(leak_num == 0, "R3 R8 settle leak", leak_num, 0);
        check(offs_num == 16, "R3 R8 settle offs", offs_num, 16);
        repeat (5) @(negedge clk);
        check(done == 1, "R7 done held", done, 1);
        check(offs_num == 16, "R7 result held", offs_num, 16);
        lk_shift = 2; of_shift = 2;
        #1;
        check(offs_shr == 4, "R6 positive shift", offs_shr, 4);
    endtask

    task automatic t_cfg(input int p, input int n, input string tag);
        pattern = 16'hFFFF; period = PW'(p); n_samples = NW'(n); settle_len = 1;
        @(negedge clk); start = 1'b1;
        @(posedge clk); @(negedge clk); start = 1'b0;
        check(done == 1, {"R9 done ", tag}, done, 1);
        check(cfg_err == 1, {"R9 err ", tag}, cfg_err, 1);
        check(busy == 0, {"R9 busy ", tag}, busy, 0);
        check(leak_num == 0 && offs_num == 0, {"R9 zero results ", tag}, leak_num, 0);
        check(stim_bit == 0, {"R9 no stim ", tag}, stim_bit, 0);
    endtask

    // modulator model: P=8, 6 ones, N=64 -> ideal leak 64, offs 0
    task automatic t_model();
        run(8, 64, 8, 16'b00111111, 2, 0);
        check(leak_num >= 56 && leak_num <= 72, "R4 model leak", leak_num, 64);
        check(offs_num >= -8 && offs_num <= 8, "R5 model offs", offs_num, 0);
        check(cfg_err == 0, "R9 err cleared", cfg_err, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_echo();
        t_const();
        t_settle();
        t_cfg(4, 10, "not multiple");
        t_cfg(0, 8, "zero period");
        t_cfg(17, 17, "period too long");
        t_cfg(4, 0, "zero N");
        t_model();
        summary();
        $finish;
    end
endmodule